// File: doc/BRIEF.md
# Contactless Type B Frame Serializer

This block turns a string of octets into the framed logical bit sequence of a contactless Type B link. The octets arrive on a byte-wide valid/ready interface with a last flag, and they already carry their CRC. The block adds the preamble, the start-of-frame and end-of-frame patterns, and the per-character start, stop and guard symbols. It sends the result one sample per transfer on a valid/ready sample interface. A `busy_o` level spans the frame and a one-clock `done_o` pulse closes it.

Two frame shapes are available, chosen by `tag_mode_i` when a frame starts. The card-response shape sends each logical symbol as four identical samples. The terminal-command shape sends one sample per symbol and closes with a long run of ones, so the last character has left the line before the link turns around. CRC generation, modulation and carrier control are handled elsewhere.

Top module: `typeb_frame_encoder`

## Requirements
- R1: After reset, `smp_valid_o`=0, `smp_bit_o`=1, `busy_o`=0, `done_o`=0 and `oct_ready_o`=0.
- R2: With `tag_mode_i`=1 at start, the accepted sample stream is as follows. Each symbol is repeated 4 times. The frame is 20 one-symbols, then 10 zero-symbols and 2 one-symbols. Each octet then follows as a 0 symbol, its 8 data bits least significant first, and a 1 symbol. The frame ends with 10 zero-symbols and 10 one-symbols.
- R3: With `tag_mode_i`=0 at start, the accepted sample stream has one sample per symbol. It is 40 ones, then 10 zeros. Each octet then follows as 1, 1, 0 and its 8 data bits least significant first. The frame ends with a single 1, 10 zeros and 32 ones.
- R4: `tag_mode_i` is read only in the cycle a frame is started; changing it during a frame does not alter that frame's samples.
- R5: `start_i` while `busy_o`=1 is ignored: the running frame is unchanged and no further frame follows it.
- R6: When the next octet is not yet offered, the block stalls without dropping, adding or altering samples, and `smp_bit_o` is 1 whenever `smp_valid_o` is 0.
- R7: While `smp_valid_o`=1 and `smp_ready_i`=0, `smp_valid_o` and `smp_bit_o` hold their values into the next cycle.
- R8: `done_o` is high for exactly one clock, in the cycle after the final sample of the frame is transferred; `busy_o` falls in that same cycle.
- R9: `oct_ready_o` is 0 while no frame is running and after the octet flagged last has been accepted; octets offered then are not consumed.
- R10: `busy_o` rises in the cycle after `start_i` is sampled high while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a frame (taken only when idle) |
| tag_mode_i | input | 1 | Frame shape: 1 card-response, 0 terminal-command |
| oct_data_i | input | 8 | Octet to send |
| oct_valid_i | input | 1 | Octet offered |
| oct_last_i | input | 1 | Offered octet ends the frame payload |
| oct_ready_o | output | 1 | Octet accepted when high together with valid |
| smp_ready_i | input | 1 | Sink takes the current sample |
| smp_valid_o | output | 1 | Sample present on `smp_bit_o` |
| smp_bit_o | output | 1 | Serial sample |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-clock end-of-frame pulse |

## Verification
The bench checks the exact sample sequence in both shapes, with octet starvation and sink back-pressure at random rates. A design that lost a sample at a stall, sent a stale octet, or repeated a symbol at a back-pressure boundary would fail the sequence comparison. Mode flips and repeated start pulses in the middle of a frame are aimed at a design that re-reads the mode pin or restarts its sequence. The done pulse is timed against the transfer of the last sample, so an early pulse (when the last sample is loaded) or a late one (after a spare cycle) is caught. Octets offered while idle, and offered after the last one, expose a ready that is raised too freely.

// File: rtl/typeb_enc_pkg.sv
package typeb_enc_pkg;

  typedef enum logic {
    LINK_READER = 1'b0,
    LINK_TAG    = 1'b1
  } link_mode_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_PRE,
    PH_SOF_LO,
    PH_SOF_HI,
    PH_CHAR,
    PH_EOF_MARK,
    PH_EOF_LO,
    PH_EOF_HI
  } phase_e;

  localparam int OCTET_BITS = 8;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/typeb_frame_seq.sv
// Symbol-level frame sequencer: walks the frame phases for the mode
// captured at start and holds the octet currently being serialized.
module typeb_frame_seq
  import typeb_enc_pkg::*;
#(
  parameter int TAG_PRE      = 20,
  parameter int TAG_SOF_LO   = 10,
  parameter int TAG_SOF_HI   = 2,
  parameter int TAG_GUARD    = 0,
  parameter int TAG_STOP     = 1,
  parameter int TAG_EOF_MARK = 0,
  parameter int TAG_EOF_LO   = 10,
  parameter int TAG_EOF_HI   = 10,
  parameter int RDR_PRE      = 40,
  parameter int RDR_SOF_LO   = 10,
  parameter int RDR_SOF_HI   = 0,
  parameter int RDR_GUARD    = 2,
  parameter int RDR_STOP     = 0,
  parameter int RDR_EOF_MARK = 1,
  parameter int RDR_EOF_LO   = 10,
  parameter int RDR_EOF_HI   = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  frame_go,
  input  link_mode_e            mode_i,
  input  logic [OCTET_BITS-1:0] oct_data_i,
  input  logic                  oct_valid_i,
  input  logic                  oct_last_i,
  output logic                  oct_ready_o,
  output link_mode_e            mode_o,
  output logic                  sym_vld,
  output logic                  sym_val,
  output logic                  sym_final,
  input  logic                  sym_take
);

  localparam int TAG_CHAR = TAG_GUARD + 1 + OCTET_BITS + TAG_STOP;
  localparam int RDR_CHAR = RDR_GUARD + 1 + OCTET_BITS + RDR_STOP;
  localparam int MAX_RUN  = imax(imax(imax(TAG_PRE, RDR_PRE), imax(TAG_CHAR, RDR_CHAR)),
                                 imax(imax(TAG_EOF_HI, RDR_EOF_HI),
                                      imax(imax(TAG_SOF_LO, RDR_SOF_LO),
                                           imax(TAG_EOF_LO, RDR_EOF_LO))));
  localparam int CW = $clog2(MAX_RUN + 1);

  phase_e                  phase, nxt_phase;
  logic [CW-1:0]           cnt;
  link_mode_e              mode_q;
  logic                    have_q;
  logic [OCTET_BITS-1:0]   oct_q;
  logic                    last_q;

  int                      run_len;
  int                      guard_len;
  int                      sof_hi_len;
  int                      mark_len;
  logic                    run_last;
  logic                    tail_take;
  logic                    in_payload;
  logic                    char_bit;
  logic [CW-1:0]           didx;

  // per-mode shape selection
  always_comb begin
    if (mode_q == LINK_TAG) begin
      guard_len  = TAG_GUARD;
      sof_hi_len = TAG_SOF_HI;
      mark_len   = TAG_EOF_MARK;
      case (phase)
        PH_PRE:      run_len = TAG_PRE;
        PH_SOF_LO:   run_len = TAG_SOF_LO;
        PH_SOF_HI:   run_len = TAG_SOF_HI;
        PH_CHAR:     run_len = TAG_CHAR;
        PH_EOF_MARK: run_len = TAG_EOF_MARK;
        PH_EOF_LO:   run_len = TAG_EOF_LO;
        PH_EOF_HI:   run_len = TAG_EOF_HI;
        default:     run_len = 1;
      endcase
    end else begin
      guard_len  = RDR_GUARD;
      sof_hi_len = RDR_SOF_HI;
      mark_len   = RDR_EOF_MARK;
      case (phase)
        PH_PRE:      run_len = RDR_PRE;
        PH_SOF_LO:   run_len = RDR_SOF_LO;
        PH_SOF_HI:   run_len = RDR_SOF_HI;
        PH_CHAR:     run_len = RDR_CHAR;
        PH_EOF_MARK: run_len = RDR_EOF_MARK;
        PH_EOF_LO:   run_len = RDR_EOF_LO;
        PH_EOF_HI:   run_len = RDR_EOF_HI;
        default:     run_len = 1;
      endcase
    end
  end

  // phase order, skipping runs of zero length
  always_comb begin
    case (phase)
      PH_PRE:      nxt_phase = PH_SOF_LO;
      PH_SOF_LO:   nxt_phase = (sof_hi_len != 0) ? PH_SOF_HI : PH_CHAR;
      PH_SOF_HI:   nxt_phase = PH_CHAR;
      PH_CHAR:     nxt_phase = (mark_len != 0) ? PH_EOF_MARK : PH_EOF_LO;
      PH_EOF_MARK: nxt_phase = PH_EOF_LO;
      PH_EOF_LO:   nxt_phase = PH_EOF_HI;
      default:     nxt_phase = PH_IDLE;
    endcase
  end

  assign run_last = (cnt == CW'(run_len - 1));

  // symbol inside one character: guard ones, start zero, data LSB first, stop ones
  assign didx = cnt - CW'(guard_len) - CW'(1);
  always_comb begin
    if (cnt < CW'(guard_len))            char_bit = 1'b1;
    else if (cnt == CW'(guard_len))      char_bit = 1'b0;
    else if (cnt <= CW'(guard_len + OCTET_BITS)) char_bit = oct_q[didx[2:0]];
    else                                 char_bit = 1'b1;
  end

  always_comb begin
    case (phase)
      PH_SOF_LO, PH_EOF_LO: sym_val = 1'b0;
      PH_CHAR:              sym_val = char_bit;
      default:              sym_val = 1'b1;
    endcase
  end

  assign sym_vld    = (phase != PH_IDLE) && ((phase != PH_CHAR) || have_q);
  assign sym_final  = (phase == PH_EOF_HI) && run_last;
  assign tail_take  = sym_take && (phase == PH_CHAR) && run_last;
  assign in_payload = (phase == PH_PRE) || (phase == PH_SOF_LO) ||
                      (phase == PH_SOF_HI) || (phase == PH_CHAR);
  assign oct_ready_o = in_payload && (!have_q || (tail_take && !last_q));
  assign mode_o      = mode_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase  <= PH_IDLE;
      cnt    <= '0;
      mode_q <= LINK_READER;
      have_q <= 1'b0;
      oct_q  <= '0;
      last_q <= 1'b0;
    end else begin
      if (frame_go && (phase == PH_IDLE)) begin
        mode_q <= mode_i;
        phase  <= PH_PRE;
        cnt    <= '0;
      end else if (sym_take) begin
        if (run_last) begin
          cnt <= '0;
          if ((phase != PH_CHAR) || last_q) phase <= nxt_phase;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
      if (oct_valid_i && oct_ready_o) begin
        have_q <= 1'b1;
        oct_q  <= oct_data_i;
        last_q <= oct_last_i;
      end else if (tail_take) begin
        have_q <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/typeb_sym_repeat.sv
// Repeats each symbol TAG_REP times in card-response mode, once otherwise.
module typeb_sym_repeat
  import typeb_enc_pkg::*;
#(
  parameter int TAG_REP = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  link_mode_e mode_i,
  input  logic       sym_vld,
  input  logic       sym_val,
  input  logic       sym_final,
  output logic       sym_take,
  output logic       smp_vld,
  output logic       smp_val,
  output logic       smp_final,
  input  logic       smp_take
);

  localparam int RW = (TAG_REP > 1) ? $clog2(TAG_REP) : 1;

  logic rep_last;

  generate
    if (TAG_REP == 1) begin : g_single
      assign rep_last = 1'b1;
    end else begin : g_count
      logic [RW-1:0] rep_cnt;
      logic [RW-1:0] reps_m1;
      assign reps_m1  = (mode_i == LINK_TAG) ? RW'(TAG_REP - 1) : '0;
      assign rep_last = (rep_cnt == reps_m1);
      always_ff @(posedge clk) begin
        if (rst)           rep_cnt <= '0;
        else if (smp_take) rep_cnt <= rep_last ? '0 : rep_cnt + 1'b1;
      end
    end
  endgenerate

  assign smp_vld   = sym_vld;
  assign smp_val   = sym_val;
  assign smp_final = sym_final && rep_last;
  assign sym_take  = smp_take && rep_last;

endmodule

// File: rtl/typeb_out_stage.sv
// Registered sample output with valid/ready; line idles at 1.
module typeb_out_stage (
  input  logic clk,
  input  logic rst,
  input  logic in_vld,
  input  logic in_val,
  input  logic in_final,
  output logic in_take,
  input  logic out_ready,
  output logic out_vld,
  output logic out_bit,
  output logic final_xfer
);

  logic fin_q;
  logic load;

  assign load       = !out_vld || out_ready;
  assign in_take    = load && in_vld;
  assign final_xfer = out_vld && out_ready && fin_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld <= 1'b0;
      out_bit <= 1'b1;
      fin_q   <= 1'b0;
    end else if (load) begin
      out_vld <= in_vld;
      out_bit <= in_vld ? in_val : 1'b1;
      fin_q   <= in_vld && in_final;
    end
  end

endmodule

// File: rtl/typeb_frame_encoder.sv
module typeb_frame_encoder
  import typeb_enc_pkg::*;
#(
  parameter int TAG_PRE      = 20,
  parameter int TAG_SOF_LO   = 10,
  parameter int TAG_SOF_HI   = 2,
  parameter int TAG_EOF_LO   = 10,
  parameter int TAG_EOF_HI   = 10,
  parameter int TAG_REP      = 4,
  parameter int RDR_PRE      = 40,
  parameter int RDR_SOF_LO   = 10,
  parameter int RDR_GUARD    = 2,
  parameter int RDR_EOF_MARK = 1,
  parameter int RDR_EOF_LO   = 10,
  parameter int RDR_EOF_ONES = 8,
  parameter int RDR_PAD      = 24
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start_i,
  input  logic       tag_mode_i,
  input  logic [7:0] oct_data_i,
  input  logic       oct_valid_i,
  input  logic       oct_last_i,
  output logic       oct_ready_o,
  input  logic       smp_ready_i,
  output logic       smp_valid_o,
  output logic       smp_bit_o,
  output logic       busy_o,
  output logic       done_o
);

  localparam int RDR_EOF_HI = RDR_EOF_ONES + RDR_PAD;

  logic       go;
  link_mode_e mode_q;
  logic       sym_vld, sym_val, sym_final, sym_take;
  logic       smp_vld, smp_val, smp_final, smp_take;
  logic       final_xfer;

  assign go = start_i && !busy_o;

  typeb_frame_seq #(
    .TAG_PRE(TAG_PRE), .TAG_SOF_LO(TAG_SOF_LO), .TAG_SOF_HI(TAG_SOF_HI),
    .TAG_GUARD(0), .TAG_STOP(1), .TAG_EOF_MARK(0),
    .TAG_EOF_LO(TAG_EOF_LO), .TAG_EOF_HI(TAG_EOF_HI),
    .RDR_PRE(RDR_PRE), .RDR_SOF_LO(RDR_SOF_LO), .RDR_SOF_HI(0),
    .RDR_GUARD(RDR_GUARD), .RDR_STOP(0), .RDR_EOF_MARK(RDR_EOF_MARK),
    .RDR_EOF_LO(RDR_EOF_LO), .RDR_EOF_HI(RDR_EOF_HI)
  ) u_seq (
    .clk        (clk),
    .rst        (rst),
    .frame_go   (go),
    .mode_i     (link_mode_e'(tag_mode_i)),
    .oct_data_i (oct_data_i),
    .oct_valid_i(oct_valid_i),
    .oct_last_i (oct_last_i),
    .oct_ready_o(oct_ready_o),
    .mode_o     (mode_q),
    .sym_vld    (sym_vld),
    .sym_val    (sym_val),
    .sym_final  (sym_final),
    .sym_take   (sym_take)
  );

  typeb_sym_repeat #(.TAG_REP(TAG_REP)) u_rep (
    .clk      (clk),
    .rst      (rst),
    .mode_i   (mode_q),
    .sym_vld  (sym_vld),
    .sym_val  (sym_val),
    .sym_final(sym_final),
    .sym_take (sym_take),
    .smp_vld  (smp_vld),
    .smp_val  (smp_val),
    .smp_final(smp_final),
    .smp_take (smp_take)
  );

  typeb_out_stage u_out (
    .clk       (clk),
    .rst       (rst),
    .in_vld    (smp_vld),
    .in_val    (smp_val),
    .in_final  (smp_final),
    .in_take   (smp_take),
    .out_ready (smp_ready_i),
    .out_vld   (smp_valid_o),
    .out_bit   (smp_bit_o),
    .final_xfer(final_xfer)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_o <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= final_xfer;
      if (go)              busy_o <= 1'b1;
      else if (final_xfer) busy_o <= 1'b0;
    end
  end

endmodule

// File: rtl/typeb_frame_encoder_chk.sv
module typeb_frame_encoder_chk (
  input logic clk,
  input logic rst,
  input logic start_i,
  input logic oct_valid_i,
  input logic oct_last_i,
  input logic oct_ready_o,
  input logic smp_ready_i,
  input logic smp_valid_o,
  input logic smp_bit_o,
  input logic busy_o,
  input logic done_o
);

  AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (rst)
    !smp_valid_o |-> smp_bit_o); // R6

  AST_HOLD_UNDER_STALL: assert property (@(posedge clk) disable iff (rst)
    (smp_valid_o && !smp_ready_i) |=> (smp_valid_o && $stable(smp_bit_o))); // R7

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R8

  AST_DONE_AFTER_XFER: assert property (@(posedge clk) disable iff (rst)
    done_o |-> ($past(smp_valid_o && smp_ready_i && busy_o) && !busy_o)); // R8

  AST_NO_READY_IDLE: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> !oct_ready_o); // R9

  AST_NO_READY_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
    (oct_valid_i && oct_ready_o && oct_last_i) |=> !oct_ready_o); // R9

  AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> $past(start_i)); // R10

  AST_SAMPLES_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
    smp_valid_o |-> busy_o); // R10

endmodule

bind typeb_frame_encoder typeb_frame_encoder_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .start_i    (start_i),
  .oct_valid_i(oct_valid_i),
  .oct_last_i (oct_last_i),
  .oct_ready_o(oct_ready_o),
  .smp_ready_i(smp_ready_i),
  .smp_valid_o(smp_valid_o),
  .smp_bit_o  (smp_bit_o),
  .busy_o     (busy_o),
  .done_o     (done_o)
);

// File: tb/typeb_frame_encoder_test.sv
`timescale 1ns/1ps
module typeb_frame_encoder_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_i = 1'b0;
  logic       tag_mode_i = 1'b0;
  logic [7:0] oct_data_i = 8'h00;
  logic       oct_valid_i = 1'b0;
  logic       oct_last_i = 1'b0;
  logic       oct_ready_o;
  logic       smp_ready_i = 1'b0;
  logic       smp_valid_o;
  logic       smp_bit_o;
  logic       busy_o;
  logic       done_o;

  int checks = 0;
  int fails  = 0;
  bit exp_q[$];
  bit got_q[$];
  logic [7:0] bytes [16];

  always #2.5 clk = ~clk;

  typeb_frame_encoder uut (
    .clk(clk), .rst(rst), .start_i(start_i), .tag_mode_i(tag_mode_i),
    .oct_data_i(oct_data_i), .oct_valid_i(oct_valid_i), .oct_last_i(oct_last_i),
    .oct_ready_o(oct_ready_o), .smp_ready_i(smp_ready_i), .smp_valid_o(smp_valid_o),
    .smp_bit_o(smp_bit_o), .busy_o(busy_o), .done_o(done_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic push_run(input bit v, input int n, input int rep);
    repeat (n * rep) exp_q.push_back(v);
  endtask

  // expected sample stream, written from R2 and R3
  task automatic build_exp(input bit tag, input int n);
    int rep;
    exp_q.delete();
    rep = tag ? 4 : 1;
    if (tag) begin
      push_run(1'b1, 20, rep); push_run(1'b0, 10, rep); push_run(1'b1, 2, rep);
    end else begin
      push_run(1'b1, 40, rep); push_run(1'b0, 10, rep);
    end
    for (int k = 0; k < n; k++) begin
      if (!tag) push_run(1'b1, 2, rep);
      push_run(1'b0, 1, rep);
      for (int j = 0; j < 8; j++) push_run(bytes[k][j], 1, rep);
      if (tag) push_run(1'b1, 1, rep);
    end
    if (tag) begin
      push_run(1'b0, 10, rep); push_run(1'b1, 10, rep);
    end else begin
      push_run(1'b1, 1, rep); push_run(1'b0, 10, rep); push_run(1'b1, 32, rep);
    end
  endtask

  task automatic run_frame(input bit tag, input int n, input int p_stall,
                           input int p_starve, input bit flip, input bit spam);
    int  idx, cyc, mism, idle_hi_bad, hold_bad, late_ready;
    bit  prev_hold, prev_bit, last_final, first, seen_done, xfer, rdy;
    string req;
    req = tag ? "R2" : "R3";
    build_exp(tag, n);
    got_q.delete();
    idx = 0; cyc = 0; idle_hi_bad = 0; hold_bad = 0; late_ready = 0;
    prev_hold = 0; prev_bit = 0; last_final = 0; first = 1; seen_done = 0;
    @(negedge clk);
    tag_mode_i = tag;
    start_i = 1'b1;
    forever begin
      @(negedge clk);
      cyc++;
      if (first) begin
        chk(busy_o == 1'b1, "R10", "busy after start", busy_o, 1);
        first = 0;
      end
      if (done_o) begin
        seen_done = 1;
        start_i = 1'b0; oct_valid_i = 1'b0; smp_ready_i = 1'b0;
        break;
      end
      if (cyc > 20000) begin
        chk(1'b0, req, "frame watchdog expired", cyc, 0);
        start_i = 1'b0; oct_valid_i = 1'b0;
        break;
      end
      if (prev_hold && !(smp_valid_o && smp_bit_o == prev_bit)) hold_bad++;
      if (!smp_valid_o && !smp_bit_o) idle_hi_bad++;
      rdy         = ($urandom % 100) >= p_stall;
      smp_ready_i = rdy;
      oct_valid_i = (idx < n) && (($urandom % 100) >= p_starve);
      oct_data_i  = oct_valid_i ? bytes[idx] : 8'($urandom);
      oct_last_i  = (idx == n - 1);
      start_i     = spam && (($urandom % 8) == 0);
      if (flip) tag_mode_i = $urandom % 2;
      #1;
      if (idx >= n && oct_ready_o) late_ready++;
      if (oct_valid_i && oct_ready_o) idx++;
      xfer = smp_valid_o && rdy;
      if (xfer) got_q.push_back(smp_bit_o);
      prev_hold  = smp_valid_o && !rdy;
      prev_bit   = smp_bit_o;
      last_final = xfer && (got_q.size() == exp_q.size());
    end
    chk(seen_done, "R8", "done seen", seen_done, 1);
    chk(last_final, "R8", "done one cycle after final transfer", last_final, 1);
    chk(busy_o == 1'b0, "R8", "busy low with done", busy_o, 0);
    chk(got_q.size() == exp_q.size(), req, "sample count", got_q.size(), exp_q.size());
    mism = 0;
    for (int i = 0; i < got_q.size() && i < exp_q.size(); i++)
      if (got_q[i] != exp_q[i]) mism++;
    chk(mism == 0, req, "mismatched samples", mism, 0);
    if (flip) chk(mism == 0, "R4", "mode change mid-frame altered samples", mism, 0);
    if (p_starve > 0) chk(idle_hi_bad == 0, "R6", "line low while no sample", idle_hi_bad, 0);
    if (p_stall > 0) chk(hold_bad == 0, "R7", "sample changed under stall", hold_bad, 0);
    chk(late_ready == 0, "R9", "ready after last octet", late_ready, 0);
    @(negedge clk);
    chk(done_o == 1'b0, "R8", "done width", done_o, 0);
    if (spam) chk(busy_o == 1'b0, "R5", "extra frame after ignored starts", busy_o, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog run did not finish actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int n;
    void'($urandom(32'h5eed_0b0b));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(smp_valid_o == 1'b0, "R1", "smp_valid after reset", smp_valid_o, 0);
    chk(smp_bit_o == 1'b1, "R1", "smp_bit after reset", smp_bit_o, 1);
    chk(busy_o == 1'b0, "R1", "busy after reset", busy_o, 0);
    chk(done_o == 1'b0, "R1", "done after reset", done_o, 0);
    chk(oct_ready_o == 1'b0, "R1", "oct_ready after reset", oct_ready_o, 0);

    // R9: octets offered while idle are not taken
    oct_valid_i = 1'b1; oct_data_i = 8'hFF; oct_last_i = 1'b1;
    for (int c = 0; c < 4; c++) begin
      #1;
      chk(oct_ready_o == 1'b0, "R9", "ready while idle", oct_ready_o, 0);
      @(negedge clk);
    end
    oct_valid_i = 1'b0;

    // directed frames
    bytes[0] = 8'hA5;
    run_frame(1'b1, 1, 0, 0, 1'b0, 1'b0);
    bytes[0] = 8'h05; bytes[1] = 8'h00; bytes[2] = 8'h08;
    run_frame(1'b0, 3, 0, 0, 1'b0, 1'b0);
    bytes[0] = 8'h80; bytes[1] = 8'h01;
    run_frame(1'b1, 2, 0, 70, 1'b0, 1'b0);
    bytes[0] = 8'h39; bytes[1] = 8'h73; bytes[2] = 8'hFF; bytes[3] = 8'h00;
    run_frame(1'b0, 4, 50, 0, 1'b1, 1'b0);
    bytes[0] = 8'h0E; bytes[1] = 8'h5B; bytes[2] = 8'hC3;
    run_frame(1'b1, 3, 30, 30, 1'b1, 1'b1);

    // random frames
    for (int f = 0; f < 10; f++) begin
      n = 1 + ($urandom % 8);
      for (int k = 0; k < n; k++) bytes[k] = 8'($urandom);
      run_frame($urandom % 2, n, $urandom % 60, $urandom % 60,
                $urandom % 2, $urandom % 2);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule